// File: doc/BRIEF.md
# 3:2 Pull-Down Field Sequencer

This block decides which frame buffer and which field of it the display reads on each output field. Film-rate material is shown on an interlaced display by stretching frames alternately over three and two output fields. The display keeps strictly alternating top and bottom slots. Because of that, the field a frame starts with flips every five output fields, and the sequencer tracks this.

On every vertical blank strobe the block advances by one output field. It either repeats a field of the current frame or moves to the next buffer in a ring. The cadence comes from one of two sources. In host mode it is a fixed 3-2 pattern. In stream mode it follows the per-frame repeat-first-field and top-field-first flags. A stall flag holds the decoder off the buffer of a frame that is still owed fields. The enable is ignored in reduced-memory operation.

Top module: `pd_pulldown_seq`

## Requirements
- R1: After reset `buf_sel_o` = NUM_BUF-1, `parity_o` = 1, `field_bot_o` = 1, `repeat_o` = 0 and `stall_o` = 0.
- R2: `parity_o` (0 = top slot, 1 = bottom slot) inverts on the cycle after every `vblank_i` pulse, whatever the cadence. No output changes in a cycle that does not follow a `vblank_i` pulse.
- R3: While pull-down is inactive, every frame lasts two fields. Its first field (`field_bot_o`: 1 = bottom) equals the parity of the slot it starts in, and its second field is the opposite one. `buf_sel_o` steps through 0 .. NUM_BUF-1 cyclically, one step per new frame.
- R4: `pd_en_i` and `reduced_mem_i` are sampled only on a `vblank_i` cycle. Toggling them between strobes has no effect.
- R5: In host mode (`src_sel_i` = 1) with pull-down active, frames alternate between 3 and 2 fields, starting with 3. Each frame's first field equals its starting slot parity, so the first field flips every five output fields.
- R6: In stream mode (`src_sel_i` = 0) with pull-down active, a frame lasts 3 fields if `rff_i` is 1 and 2 fields otherwise. Its first field is bottom when `tff_i` is 0. Both flags are sampled on the strobe that starts the frame.
- R7: In the third field of a frame, `repeat_o` = 1, and that field reads the same buffer and the same field as the frame's first field.
- R8: While pull-down is active, `stall_o` is 1 during the first two fields of a 3-field frame. It is 0 from the strobe that starts the frame's last field, and it is never 1 together with `repeat_o`.
- R9: While `reduced_mem_i` = 1, the enable is treated as 0: no repeats and no stall.
- R10: Clearing the enable in the middle of a 3-field frame, after its first field, ends that frame at the next strobe, and plain two-field display resumes.
- R11: In host mode, re-arming the enable restarts the cadence, so the first frame after it lasts 3 fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_en_i | input | 1 | Pull-down enable, sampled at vertical blank |
| src_sel_i | input | 1 | Cadence source: 0 stream flags, 1 host fixed pattern |
| rff_i | input | 1 | Repeat-first-field flag of the next frame |
| tff_i | input | 1 | Top-field-first flag of the next frame |
| vblank_i | input | 1 | One-cycle vertical blank strobe |
| reduced_mem_i | input | 1 | Reduced-memory operation; forces pull-down off |
| buf_sel_o | output | BUF_W | Frame buffer shown in the current field |
| field_bot_o | output | 1 | Field read from that buffer: 1 bottom, 0 top |
| parity_o | output | 1 | Output slot parity: 1 bottom, 0 top |
| repeat_o | output | 1 | Current field repeats the frame's first field |
| stall_o | output | 1 | Decoder must not overwrite the shown frame |

## Verification
The hardest case to reach is a frame whose cadence changes under it: an enable cleared after the first field of a 3-field frame, or re-armed in host mode, must truncate that frame or restart the 3-2 phase. The stimulus walks the host cadence to such a frame before flipping the enable, and it also toggles the enable between strobes to show those toggles are ignored. A bench model tracks slot parity, field index and buffer, so every strobe is compared against the expected field, repeat and stall.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  typedef logic [1:0] fcnt_t;
  localparam fcnt_t LEN_PLAIN = 2'd2;
  localparam fcnt_t LEN_LONG  = 2'd3;
  typedef enum logic {SRC_STREAM = 1'b0, SRC_HOST = 1'b1} src_e;
endpackage

// File: rtl/pd_cadence.sv
module pd_cadence
  import pd_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  vblank_i,
  input  logic  active_nxt_i,
  input  logic  new_frame_i,
  input  logic  src_sel_i,
  input  logic  rff_i,
  input  logic  tff_i,
  input  logic  parity_nxt_i,
  output fcnt_t len_o,
  output logic  first_bot_o
);
  logic phase_q;

  always_comb begin
    if (!active_nxt_i) begin
      len_o       = LEN_PLAIN;
      first_bot_o = parity_nxt_i;
    end else if (src_e'(src_sel_i) == SRC_HOST) begin
      len_o       = phase_q ? LEN_PLAIN : LEN_LONG;
      first_bot_o = parity_nxt_i;
    end else begin
      len_o       = rff_i ? LEN_LONG : LEN_PLAIN;
      first_bot_o = ~tff_i;
    end
  end

  // phase 0 -> 3-field frame; cleared whenever pull-down is off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else if (vblank_i) begin
      if (!active_nxt_i) phase_q <= 1'b0;
      else if (new_frame_i && src_e'(src_sel_i) == SRC_HOST) phase_q <= ~phase_q;
    end
  end
endmodule

// File: rtl/pd_field_ctr.sv
module pd_field_ctr
  import pd_seq_pkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int BUF_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vblank_i,
  input  logic             active_nxt_i,
  input  fcnt_t            nxt_len_i,
  input  logic             nxt_first_bot_i,
  output logic             new_frame_o,
  output fcnt_t            cnt_o,
  output fcnt_t            len_o,
  output logic             first_bot_o,
  output logic [BUF_W-1:0] buf_o,
  output logic             parity_o
);
  localparam logic [BUF_W-1:0] BUF_LAST = BUF_W'(NUM_BUF - 1);

  fcnt_t            cnt_q, len_q;
  logic             first_q, par_q;
  logic [BUF_W-1:0] buf_q;

  // last field done, or pull-down dropped after the first field
  assign new_frame_o = ({1'b0, cnt_q} + 3'd1 >= {1'b0, len_q}) ||
                       (!active_nxt_i && cnt_q != 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= 2'd1;
      len_q   <= LEN_PLAIN;
      first_q <= 1'b0;
      buf_q   <= BUF_LAST;
      par_q   <= 1'b1;
    end else if (vblank_i) begin
      par_q <= ~par_q;
      if (new_frame_o) begin
        cnt_q   <= 2'd0;
        len_q   <= nxt_len_i;
        first_q <= nxt_first_bot_i;
        buf_q   <= (buf_q == BUF_LAST) ? '0 : buf_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign cnt_o       = cnt_q;
  assign len_o       = len_q;
  assign first_bot_o = first_q;
  assign buf_o       = buf_q;
  assign parity_o    = par_q;
endmodule

// File: rtl/pd_pulldown_seq.sv
module pd_pulldown_seq
  import pd_seq_pkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int BUF_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_en_i,
  input  logic             src_sel_i,
  input  logic             rff_i,
  input  logic             tff_i,
  input  logic             vblank_i,
  input  logic             reduced_mem_i,
  output logic [BUF_W-1:0] buf_sel_o,
  output logic             field_bot_o,
  output logic             parity_o,
  output logic             repeat_o,
  output logic             stall_o
);
  logic  active_q, active_nxt, new_frame, nxt_first, first_bot;
  fcnt_t nxt_len, cnt, len;

  assign active_nxt = pd_en_i & ~reduced_mem_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       active_q <= 1'b0;
    else if (vblank_i) active_q <= active_nxt;
  end

  pd_cadence u_cad (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vblank_i     (vblank_i),
    .active_nxt_i (active_nxt),
    .new_frame_i  (new_frame),
    .src_sel_i    (src_sel_i),
    .rff_i        (rff_i),
    .tff_i        (tff_i),
    .parity_nxt_i (~parity_o),
    .len_o        (nxt_len),
    .first_bot_o  (nxt_first)
  );

  pd_field_ctr #(.NUM_BUF(NUM_BUF), .BUF_W(BUF_W)) u_ctr (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .vblank_i        (vblank_i),
    .active_nxt_i    (active_nxt),
    .nxt_len_i       (nxt_len),
    .nxt_first_bot_i (nxt_first),
    .new_frame_o     (new_frame),
    .cnt_o           (cnt),
    .len_o           (len),
    .first_bot_o     (first_bot),
    .buf_o           (buf_sel_o),
    .parity_o        (parity_o)
  );

  // third field (cnt 2) has cnt[0]=0, so it reads the first field again
  assign field_bot_o = first_bot ^ cnt[0];
  assign repeat_o    = (cnt == 2'd2);
  assign stall_o     = active_q && (len == LEN_LONG) && (cnt < 2'd2);
endmodule

// File: rtl/pd_pulldown_seq_chk.sv
module pd_pulldown_seq_chk #(
  parameter int BUF_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             vblank_i,
  input logic             reduced_mem_i,
  input logic [BUF_W-1:0] buf_sel_o,
  input logic             field_bot_o,
  input logic             parity_o,
  input logic             repeat_o,
  input logic             stall_o
);
  AST_PARITY_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_i |=> parity_o != $past(parity_o)); // R2
  AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vblank_i |=> $stable(buf_sel_o) && $stable(parity_o) && $stable(field_bot_o)
                  && $stable(repeat_o) && $stable(stall_o)); // R4
  AST_REPEAT_SAME_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(repeat_o) |-> $stable(buf_sel_o)); // R7
  AST_STALL_NOT_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !repeat_o); // R8
  AST_REDUCED_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_i && reduced_mem_i |=> !stall_o && !repeat_o); // R9
endmodule

bind pd_pulldown_seq pd_pulldown_seq_chk #(.BUF_W(BUF_W)) u_chk (.*);

// File: tb/sim_pd_pulldown_seq.sv
module sim_pd_pulldown_seq;
  localparam int NB = 3;
  localparam int BW = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pd_en = 0, src = 0, rff = 0, tff = 1, vbl = 0, red = 0;
  logic [BW-1:0] buf_sel;
  logic field_bot, parity, rep, stall;

  int n_run = 0, n_fail = 0;

  typedef struct {
    int buf_e; bit fb; bit par; bit rp; bit st; string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  pd_pulldown_seq #(.NUM_BUF(NB)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pd_en_i(pd_en), .src_sel_i(src),
    .rff_i(rff), .tff_i(tff), .vblank_i(vbl), .reduced_mem_i(red),
    .buf_sel_o(buf_sel), .field_bot_o(field_bot), .parity_o(parity),
    .repeat_o(rep), .stall_o(stall));

  // reference state
  int m_buf = NB - 1, m_idx = 1, m_len = 2;
  bit m_par = 1, m_first = 0, m_phase = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: compute expectation, issue one strobe
  task automatic step(bit en, bit s, bit f_rff, bit f_tff, bit rm, string tag);
    exp_t e;
    bit act, nf;
    act = en && !rm;
    m_par = !m_par;
    nf = (m_idx + 1 >= m_len) || (!act && m_idx >= 1);
    if (nf) begin
      m_buf = (m_buf + 1) % NB;
      m_idx = 0;
      if (!act) begin m_len = 2; m_first = m_par; end
      else if (s) begin m_len = m_phase ? 2 : 3; m_first = m_par; m_phase = !m_phase; end
      else begin m_len = f_rff ? 3 : 2; m_first = !f_tff; end
    end else m_idx++;
    if (!act) m_phase = 0;
    e.buf_e = m_buf;
    e.fb    = m_first ^ m_idx[0];
    e.par   = m_par;
    e.rp    = (m_idx == 2);
    e.st    = act && m_len == 3 && m_idx < 2;
    e.tag   = tag;
    @(negedge clk);
    pd_en = en; src = s; rff = f_rff; tff = f_tff; red = rm;
    q.push_back(e);
    vbl = 1'b1;
    @(negedge clk);
    vbl = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      if (vbl === 1'b1) begin
        exp_t e;
        @(negedge clk);
        e = q.pop_front();
        chk(e.tag, "buf_sel", int'(buf_sel), e.buf_e);
        chk(e.tag, "field_bot", int'(field_bot), int'(e.fb));
        chk("R2", "parity", int'(parity), int'(e.par));
        chk("R7", "repeat", int'(rep), int'(e.rp));
        chk("R8", "stall", int'(stall), int'(e.st));
      end
    end
  end

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [BW-1:0] b0;
    logic f0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "buf_sel", int'(buf_sel), NB - 1);
    chk("R1", "parity", int'(parity), 1);
    chk("R1", "field_bot", int'(field_bot), 1);
    chk("R1", "repeat", int'(rep), 0);
    chk("R1", "stall", int'(stall), 0);

    // R3 plain display
    for (int i = 0; i < 5; i++) step(0, 1, 0, 1, 0, "R3");

    // R4 toggle between strobes: nothing moves
    b0 = buf_sel; f0 = field_bot;
    pd_en = 1; red = 1; repeat (2) @(negedge clk);
    pd_en = 0; red = 0; @(negedge clk);
    chk("R4", "buf_sel held", int'(buf_sel), int'(b0));
    chk("R4", "field_bot held", int'(field_bot), int'(f0));
    chk("R4", "stall held", int'(stall), 0);
    step(0, 1, 0, 1, 0, "R4");
    step(0, 1, 0, 1, 0, "R4");

    // R5 host cadence
    for (int i = 0; i < 12; i++) step(1, 1, 0, 1, 0, "R5");

    // R10 drop enable mid 3-field frame after its first field
    while (!(m_len == 3 && m_idx == 0)) step(1, 1, 0, 1, 0, "R5");
    step(1, 1, 0, 1, 0, "R5");
    step(0, 1, 0, 1, 0, "R10");
    step(0, 1, 0, 1, 0, "R10");
    step(0, 1, 0, 1, 0, "R10");

    // R11 re-arm host mode restarts at a 3-field frame
    for (int i = 0; i < 6; i++) step(1, 1, 0, 1, 0, "R11");
    step(0, 1, 0, 1, 0, "R11");
    step(0, 1, 0, 1, 0, "R11");
    for (int i = 0; i < 5; i++) step(1, 1, 0, 1, 0, "R11");

    // R6 stream flags
    for (int i = 0; i < 16; i++) step(1, 0, i[1], i[2] ^ i[0], 0, "R6");

    // R9 reduced memory forces plain display
    for (int i = 0; i < 6; i++) step(1, i[0], 1, 0, 1, "R9");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0, "R5");
    step(1, 1, 0, 1, 1, "R9");
    step(1, 1, 0, 1, 1, "R9");

    repeat (4) @(negedge clk);
    chk("R2", "queue drained", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule